// File: doc/BRIEF.md
# Two-Stage Address Translation Sequencer

This block sits between a memory access requester and a shared page-table walker. For each request it works out the effective privilege and whether the access needs one translation stage or two. It also picks the root register for the first stage: the normal supervisor root or the virtual-supervisor root. It then drives the walker one operation at a time. The walker offers two operations. One fully translates a guest physical address through the second stage. The other reads a single first-stage table entry at a host physical address.

In two-stage mode, each first-stage table base is a guest physical address. The block sends it through the second stage before it forms the entry address. The leaf result of the first stage is an intermediate guest physical address, and a final second-stage translation turns it into the host address. The single response carries the physical address or a fault. A fault is tagged either as a first-stage page fault or as a guest-physical fault for the hypervisor, and a guest-physical fault also carries its faulting address shifted right by two. Permission and physical-memory-protection checks belong to other blocks.

Top module: `tstage_xlat_seq`

## Requirements
- R1: The block skips the first stage when the effective privilege is machine (code 3) or the selected first-stage root is off. Without two-stage mode the response address is then the virtual address zero-extended, with no walker operation.
- R2: Two-stage mode applies when virtualization is on. It also applies for a non-fetch machine-mode access with both the modify-privilege bit and the previous-virtualization bit set. It also applies for a non-fetch non-virtualized supervisor access with both the supervisor modify-privilege bit and the supervisor previous-virtualization bit set. When the first stage is skipped in two-stage mode, the virtual address goes straight to the final second-stage translation.
- R3: A non-fetch machine-mode access with the modify-privilege bit set takes its effective privilege from the saved previous privilege. If the previous-virtualization bit is also set, the first stage uses the virtual-supervisor root.
- R4: A non-fetch, non-virtualized access with effective supervisor privilege and the supervisor modify-privilege bit set selects the virtual-supervisor root. Its privilege then comes from the saved supervisor previous-privilege bit (1 = supervisor, 0 = user). A virtualized access also uses the virtual-supervisor root.
- R5: Instruction fetches (access code 2) ignore both modify-privilege overrides. Loads are code 0 and stores are code 1.
- R6: In two-stage mode, every first-stage table base is first sent to the walker as a second-stage operation (op code 0). The entry read (op code 1) then goes to the returned host base plus the level index times 4 bytes.
- R7: A second-stage operation carries the guest root register (enable bit and page number). A first-stage leaf result in two-stage mode, with the page offset of the virtual address appended, goes through one final second-stage operation.
- R8: A failed second-stage operation reports fault=1, stage1=0 and physical address 0. For the final translation the fault value is the intermediate address (page offset included) shifted right by 2. For a table-base translation it is the table base shifted right by 2.
- R9: An entry is a first-stage fault in four cases: the walker reports an error on the entry read, the valid bit (bit 0) is clear, write (bit 2) is set without read (bit 1), or a non-leaf entry sits at the last level. Leaf means read or execute (bit 3) is set. The response is then fault=1, stage1=1, fault value 0.
- R10: The fault value and the stage flag are cleared when each request is accepted, so a successful response always reports 0 in both.
- R11: A leaf found above the last level is a superpage. The low page-number bits, level times index width of them, come from the virtual page number. The entry's page number sits in bits 31:10.
- R12: Only one request is in flight. The block is ready only when idle. A response is held until it is taken, and a walker request is held until it is accepted.
- R13: A single-stage walk starts at the selected root page number times the page size. It reads the entries directly, with no second-stage operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and accepting |
| req_vaddr | input | VA_W | Virtual address |
| req_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| req_virt | input | 1 | Virtualization active |
| req_acc | input | 2 | Access type (0 load, 1 store, 2 fetch) |
| st_mprv | input | 1 | Machine modify-privilege bit |
| st_mpv | input | 1 | Machine previous-virtualization bit |
| st_mpp | input | 2 | Machine previous privilege |
| st_sprv | input | 1 | Supervisor modify-privilege bit |
| st_spv | input | 1 | Supervisor previous-virtualization bit |
| st_spp | input | 1 | Supervisor previous privilege |
| root_s_on | input | 1 | Supervisor root translation enabled |
| root_s_ppn | input | PPN_W | Supervisor root page number |
| root_vs_on | input | 1 | Virtual-supervisor root enabled |
| root_vs_ppn | input | PPN_W | Virtual-supervisor root page number |
| root_g_on | input | 1 | Guest (second-stage) root enabled |
| root_g_ppn | input | PPN_W | Guest root page number |
| wk_req_valid | output | 1 | Walker operation valid |
| wk_req_ready | input | 1 | Walker accepts operation |
| wk_req_op | output | 1 | 0 second-stage translate, 1 entry read |
| wk_req_addr | output | PA_W | Operation address |
| wk_req_root_on | output | 1 | Second-stage root enable for the operation |
| wk_req_root_ppn | output | PPN_W | Second-stage root page number |
| wk_rsp_valid | input | 1 | Walker result valid |
| wk_rsp_fault | input | 1 | Walker operation failed |
| wk_rsp_data | input | PA_W | Translated address or entry (low 32 bits) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_paddr | output | PA_W | Final physical address |
| rsp_fault | output | 1 | Translation failed |
| rsp_stage1 | output | 1 | Fault came from the first stage |
| rsp_gpf | output | PA_W | Guest-physical fault value |

## Verification
The assertions check the handshake rules on every cycle: no acceptance while busy, no walker traffic while idle, and responses and walker requests held while stalled. They also check that the response fields agree with each other: a success carries no fault value or stage flag, a first-stage fault carries no fault value, and a fault carries no address. Only the bench scenarios can show the routing decisions, such as the override privileges, the root selection, the fetch exemption and the nesting of second-stage operations on every table base. The bench checks these against a walker model through the final address and the count of walker operations each request produced. The scenarios also cover the fault values, the superpage fill and the clearing of the fault value between requests.

// File: rtl/tstage_xlat_pkg.sv
package tstage_xlat_pkg;

    localparam logic [1:0] P_USER    = 2'd0;
    localparam logic [1:0] P_SUPER   = 2'd1;
    localparam logic [1:0] P_MACHINE = 2'd3;

    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic WOP_GUEST = 1'b0;
    localparam logic WOP_ENTRY = 1'b1;

    localparam int ENT_V = 0;
    localparam int ENT_R = 1;
    localparam int ENT_W = 2;
    localparam int ENT_X = 3;

    typedef struct packed {
        logic two_stage;
        logic use_vs;
        logic s1_skip;
    } route_t;

    typedef enum logic [1:0] {
        EK_BAD,
        EK_NEXT,
        EK_LEAF
    } ent_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE_REQ,
        ST_BASE_WAIT,
        ST_ENT_REQ,
        ST_ENT_WAIT,
        ST_FIN_REQ,
        ST_FIN_WAIT,
        ST_DONE
    } seq_state_e;

    function automatic logic is_fetch(input logic [1:0] acc);
        return acc == ACC_FETCH;
    endfunction

endpackage

// File: rtl/xlat_route_dec.sv
module xlat_route_dec
    import tstage_xlat_pkg::*;
#(
    parameter bit HEXT = 1'b1
) (
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic [1:0] acc,
    input  logic       mprv,
    input  logic       mpv,
    input  logic [1:0] mpp,
    input  logic       sprv,
    input  logic       spv,
    input  logic       spp,
    input  logic       s_on,
    input  logic       vs_on,
    output route_t     route
);
    logic [1:0] eff;
    logic       sel_vs;
    logic       fetch;
    logic       root_on;

    always_comb begin
        fetch  = is_fetch(acc);
        eff    = priv;
        sel_vs = HEXT && virt;
        if (priv == P_MACHINE && !fetch && mprv) begin
            eff = mpp;
            if (HEXT && mpv) sel_vs = 1'b1;
        end
        if (eff == P_SUPER && !fetch && HEXT && !virt && sprv) begin
            eff    = spp ? P_SUPER : P_USER;
            sel_vs = 1'b1;
        end
        root_on         = sel_vs ? vs_on : s_on;
        route.use_vs    = sel_vs;
        route.s1_skip   = (eff == P_MACHINE) || !root_on;
        route.two_stage = HEXT && (virt
                          || (priv == P_MACHINE && !fetch && mprv && mpv)
                          || (priv == P_SUPER && !virt && !fetch && sprv && spv));
    end
endmodule

// File: rtl/xlat_entry_eval.sv
module xlat_entry_eval
    import tstage_xlat_pkg::*;
#(
    parameter int LEVELS    = 2,
    parameter int IDX_BITS  = 10,
    parameter int PAGE_BITS = 12,
    parameter int PPN_W     = 22,
    parameter int PTE_W     = 32,
    parameter int PTE_BYTES = 4,
    parameter int VA_W      = PAGE_BITS + LEVELS * IDX_BITS,
    parameter int PA_W      = PPN_W + PAGE_BITS,
    parameter int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [PTE_W-1:0] entry,
    input  logic [LVL_W-1:0] level,
    input  logic [VA_W-1:0]  vaddr,
    output ent_kind_e        kind,
    output logic [PA_W-1:0]  next_base,
    output logic [PA_W-1:0]  leaf_addr,
    output logic [PA_W-1:0]  ent_off
);
    localparam int OFF_SH = $clog2(PTE_BYTES);

    logic [PPN_W-1:0] ppn;
    logic [PPN_W-1:0] vpn_ext;
    logic [PPN_W-1:0] low_mask;
    logic [VA_W-1:0]  va_sh;
    logic             v, r, w, x;
    logic             unused_flags;

    assign ppn          = entry[PTE_W-1:PTE_W-PPN_W];
    assign v            = entry[ENT_V];
    assign r            = entry[ENT_R];
    assign w            = entry[ENT_W];
    assign x            = entry[ENT_X];
    assign unused_flags = ^entry[PTE_W-PPN_W-1:ENT_X+1];

    always_comb begin
        va_sh    = vaddr >> (PAGE_BITS + int'(level) * IDX_BITS);
        ent_off  = PA_W'(va_sh[IDX_BITS-1:0]) << OFF_SH;
        vpn_ext  = PPN_W'(vaddr[VA_W-1:PAGE_BITS]);
        low_mask = ~({PPN_W{1'b1}} << (int'(level) * IDX_BITS));
        leaf_addr = {(ppn & ~low_mask) | (vpn_ext & low_mask), vaddr[PAGE_BITS-1:0]};
        next_base = {ppn, {PAGE_BITS{1'b0}}};
        if (!v || (w && !r))       kind = EK_BAD;
        else if (r || x)           kind = EK_LEAF;
        else if (level == '0)      kind = EK_BAD;
        else                       kind = EK_NEXT;
    end
endmodule

// File: rtl/tstage_xlat_seq.sv
module tstage_xlat_seq
    import tstage_xlat_pkg::*;
#(
    parameter bit HEXT      = 1'b1,
    parameter int LEVELS    = 2,
    parameter int IDX_BITS  = 10,
    parameter int PAGE_BITS = 12,
    parameter int PPN_W     = 22,
    parameter int PTE_W     = 32,
    parameter int PTE_BYTES = 4,
    parameter int VA_W      = PAGE_BITS + LEVELS * IDX_BITS,
    parameter int PA_W      = PPN_W + PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_priv,
    input  logic             req_virt,
    input  logic [1:0]       req_acc,
    input  logic             st_mprv,
    input  logic             st_mpv,
    input  logic [1:0]       st_mpp,
    input  logic             st_sprv,
    input  logic             st_spv,
    input  logic             st_spp,
    input  logic             root_s_on,
    input  logic [PPN_W-1:0] root_s_ppn,
    input  logic             root_vs_on,
    input  logic [PPN_W-1:0] root_vs_ppn,
    input  logic             root_g_on,
    input  logic [PPN_W-1:0] root_g_ppn,
    output logic             wk_req_valid,
    input  logic             wk_req_ready,
    output logic             wk_req_op,
    output logic [PA_W-1:0]  wk_req_addr,
    output logic             wk_req_root_on,
    output logic [PPN_W-1:0] wk_req_root_ppn,
    input  logic             wk_rsp_valid,
    input  logic             wk_rsp_fault,
    input  logic [PA_W-1:0]  wk_rsp_data,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             rsp_stage1,
    output logic [PA_W-1:0]  rsp_gpf
);
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

    seq_state_e       state_q;
    route_t           route;
    logic             two_q;
    logic [VA_W-1:0]  va_q;
    logic [LVL_W-1:0] level_q;
    logic [PA_W-1:0]  base_q;
    logic [PA_W-1:0]  hbase_q;
    logic [PA_W-1:0]  gpa_q;
    logic [PA_W-1:0]  pa_q;
    logic             fault_q;
    logic             s1_q;
    logic [PA_W-1:0]  gpf_q;
    logic [PPN_W-1:0] root1_ppn;

    ent_kind_e        e_kind;
    logic [PA_W-1:0]  e_next;
    logic [PA_W-1:0]  e_leaf;
    logic [PA_W-1:0]  e_off;

    xlat_route_dec #(.HEXT(HEXT)) route_i (
        .priv  (req_priv),
        .virt  (req_virt),
        .acc   (req_acc),
        .mprv  (st_mprv),
        .mpv   (st_mpv),
        .mpp   (st_mpp),
        .sprv  (st_sprv),
        .spv   (st_spv),
        .spp   (st_spp),
        .s_on  (root_s_on),
        .vs_on (root_vs_on),
        .route (route)
    );

    xlat_entry_eval #(
        .LEVELS   (LEVELS),
        .IDX_BITS (IDX_BITS),
        .PAGE_BITS(PAGE_BITS),
        .PPN_W    (PPN_W),
        .PTE_W    (PTE_W),
        .PTE_BYTES(PTE_BYTES),
        .VA_W     (VA_W),
        .PA_W     (PA_W),
        .LVL_W    (LVL_W)
    ) entry_i (
        .entry    (wk_rsp_data[PTE_W-1:0]),
        .level    (level_q),
        .vaddr    (va_q),
        .kind     (e_kind),
        .next_base(e_next),
        .leaf_addr(e_leaf),
        .ent_off  (e_off)
    );

    assign root1_ppn = route.use_vs ? root_vs_ppn : root_s_ppn;

    always_comb begin
        req_ready       = (state_q == ST_IDLE);
        wk_req_valid    = (state_q == ST_BASE_REQ) || (state_q == ST_ENT_REQ)
                          || (state_q == ST_FIN_REQ);
        wk_req_op       = (state_q == ST_ENT_REQ) ? WOP_ENTRY : WOP_GUEST;
        wk_req_root_on  = root_g_on;
        wk_req_root_ppn = root_g_ppn;
        case (state_q)
            ST_BASE_REQ: wk_req_addr = base_q;
            ST_ENT_REQ:  wk_req_addr = hbase_q + e_off;
            default:     wk_req_addr = gpa_q;
        endcase
        rsp_valid  = (state_q == ST_DONE);
        rsp_paddr  = pa_q;
        rsp_fault  = fault_q;
        rsp_stage1 = s1_q;
        rsp_gpf    = gpf_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            two_q   <= 1'b0;
            va_q    <= '0;
            level_q <= '0;
            base_q  <= '0;
            hbase_q <= '0;
            gpa_q   <= '0;
            pa_q    <= '0;
            fault_q <= 1'b0;
            s1_q    <= 1'b0;
            gpf_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    va_q    <= req_vaddr;
                    two_q   <= route.two_stage;
                    pa_q    <= '0;
                    fault_q <= 1'b0;
                    s1_q    <= 1'b0;
                    gpf_q   <= '0;
                    level_q <= TOP_LVL;
                    base_q  <= {root1_ppn, {PAGE_BITS{1'b0}}};
                    hbase_q <= {root1_ppn, {PAGE_BITS{1'b0}}};
                    if (route.s1_skip) begin
                        if (route.two_stage) begin
                            gpa_q   <= PA_W'(req_vaddr);
                            state_q <= ST_FIN_REQ;
                        end else begin
                            pa_q    <= PA_W'(req_vaddr);
                            state_q <= ST_DONE;
                        end
                    end else begin
                        state_q <= route.two_stage ? ST_BASE_REQ : ST_ENT_REQ;
                    end
                end
                ST_BASE_REQ: if (wk_req_ready) state_q <= ST_BASE_WAIT;
                ST_BASE_WAIT: if (wk_rsp_valid) begin
                    if (wk_rsp_fault) begin
                        fault_q <= 1'b1;
                        gpf_q   <= base_q >> 2;
                        state_q <= ST_DONE;
                    end else begin
                        hbase_q <= wk_rsp_data;
                        state_q <= ST_ENT_REQ;
                    end
                end
                ST_ENT_REQ: if (wk_req_ready) state_q <= ST_ENT_WAIT;
                ST_ENT_WAIT: if (wk_rsp_valid) begin
                    if (wk_rsp_fault || e_kind == EK_BAD) begin
                        fault_q <= 1'b1;
                        s1_q    <= 1'b1;
                        state_q <= ST_DONE;
                    end else if (e_kind == EK_NEXT) begin
                        base_q  <= e_next;
                        hbase_q <= e_next;
                        level_q <= level_q - 1'b1;
                        state_q <= two_q ? ST_BASE_REQ : ST_ENT_REQ;
                    end else if (two_q) begin
                        gpa_q   <= e_leaf;
                        state_q <= ST_FIN_REQ;
                    end else begin
                        pa_q    <= e_leaf;
                        state_q <= ST_DONE;
                    end
                end
                ST_FIN_REQ: if (wk_req_ready) state_q <= ST_FIN_WAIT;
                ST_FIN_WAIT: if (wk_rsp_valid) begin
                    if (wk_rsp_fault) begin
                        fault_q <= 1'b1;
                        gpf_q   <= gpa_q >> 2;
                    end else begin
                        pa_q <= wk_rsp_data;
                    end
                    state_q <= ST_DONE;
                end
                ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tstage_xlat_chk.sv
module tstage_xlat_chk #(
    parameter int PA_W = 34
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            wk_req_valid,
    input logic            wk_req_ready,
    input logic            wk_req_op,
    input logic [PA_W-1:0] wk_req_addr,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_fault,
    input logic            rsp_stage1,
    input logic [PA_W-1:0] rsp_gpf
);
    a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    a_r12_idle_no_walk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !wk_req_valid);

    a_r12_single_flight: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r12_rsp_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                       && $stable(rsp_fault) && $stable(rsp_gpf)));

    a_r12_wk_hold: assert property (@(posedge clk) disable iff (rst)
        (wk_req_valid && !wk_req_ready) |=> (wk_req_valid && $stable(wk_req_addr)
                                             && $stable(wk_req_op)));

    a_r9_stage1_clean: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_stage1) |-> (rsp_fault && rsp_gpf == '0));

    a_r10_ok_clean: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (!rsp_stage1 && rsp_gpf == '0));

    a_r8_fault_no_addr: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

bind tstage_xlat_seq tstage_xlat_chk #(.PA_W(PA_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .wk_req_valid(wk_req_valid),
    .wk_req_ready(wk_req_ready),
    .wk_req_op   (wk_req_op),
    .wk_req_addr (wk_req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_paddr   (rsp_paddr),
    .rsp_fault   (rsp_fault),
    .rsp_stage1  (rsp_stage1),
    .rsp_gpf     (rsp_gpf)
);

// File: tb/tstage_xlat_seq_tb_top.sv
`timescale 1ns/1ps
module tstage_xlat_seq_tb_top;
    localparam int VA_W  = 32;
    localparam int PA_W  = 34;
    localparam int PPN_W = 22;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic [1:0]       req_priv = 2'd0;
    logic             req_virt = 1'b0;
    logic [1:0]       req_acc = 2'd0;
    logic             st_mprv = 1'b0, st_mpv = 1'b0, st_sprv = 1'b0, st_spv = 1'b0, st_spp = 1'b0;
    logic [1:0]       st_mpp = 2'd0;
    logic             root_s_on = 1'b1, root_vs_on = 1'b1, root_g_on = 1'b1;
    logic [PPN_W-1:0] root_s_ppn = 22'h100, root_vs_ppn = 22'h300, root_g_ppn = 22'h1000;
    logic             wk_req_valid;
    logic             wk_req_ready = 1'b1;
    logic             wk_req_op;
    logic [PA_W-1:0]  wk_req_addr;
    logic             wk_req_root_on;
    logic [PPN_W-1:0] wk_req_root_ppn;
    logic             wk_rsp_valid = 1'b0;
    logic             wk_rsp_fault = 1'b0;
    logic [PA_W-1:0]  wk_rsp_data = '0;
    logic             rsp_valid;
    logic             rsp_ready = 1'b1;
    logic [PA_W-1:0]  rsp_paddr;
    logic             rsp_fault;
    logic             rsp_stage1;
    logic [PA_W-1:0]  rsp_gpf;

    always #2.5 clk = ~clk;

    tstage_xlat_seq dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_priv(req_priv), .req_virt(req_virt), .req_acc(req_acc),
        .st_mprv(st_mprv), .st_mpv(st_mpv), .st_mpp(st_mpp),
        .st_sprv(st_sprv), .st_spv(st_spv), .st_spp(st_spp),
        .root_s_on(root_s_on), .root_s_ppn(root_s_ppn),
        .root_vs_on(root_vs_on), .root_vs_ppn(root_vs_ppn),
        .root_g_on(root_g_on), .root_g_ppn(root_g_ppn),
        .wk_req_valid(wk_req_valid), .wk_req_ready(wk_req_ready),
        .wk_req_op(wk_req_op), .wk_req_addr(wk_req_addr),
        .wk_req_root_on(wk_req_root_on), .wk_req_root_ppn(wk_req_root_ppn),
        .wk_rsp_valid(wk_rsp_valid), .wk_rsp_fault(wk_rsp_fault), .wk_rsp_data(wk_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_stage1(rsp_stage1), .rsp_gpf(rsp_gpf)
    );

    // Walker model: entry memory plus an offset-style second stage that
    // fails for addresses whose two top bits are both set.
    logic [31:0] mem [logic [PA_W-1:0]];
    int          ops_total = 0;

    always @(posedge clk) begin
        wk_rsp_valid <= 1'b0;
        if (!rst && wk_req_valid && wk_req_ready) begin
            ops_total    <= ops_total + 1;
            wk_rsp_valid <= 1'b1;
            wk_rsp_fault <= 1'b0;
            if (wk_req_op) begin
                wk_rsp_data <= mem.exists(wk_req_addr) ? PA_W'(mem[wk_req_addr]) : '0;
            end else if (!wk_req_root_on) begin
                wk_rsp_data <= wk_req_addr;
            end else if (wk_req_addr[PA_W-1:PA_W-2] == 2'b11) begin
                wk_rsp_fault <= 1'b1;
                wk_rsp_data  <= '0;
            end else begin
                wk_rsp_data <= wk_req_addr + {wk_req_root_ppn, 12'h000};
            end
        end
    end

    typedef struct {
        string           tag;
        logic [PA_W-1:0] pa;
        logic            fault;
        logic            s1;
        logic [PA_W-1:0] gpf;
        int              ops;
        int              ops_base;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   fails = 0;
    int   done_cnt = 0;
    bit   finished = 1'b0;

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per accepted response.
    always @(negedge clk) begin
        if (!rst && rsp_valid && rsp_ready) begin
            if (sb_q.size() == 0) begin
                chk("R12", "unexpected response", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, "paddr", 64'(rsp_paddr), 64'(e.pa));
                chk(e.tag, "fault", 64'(rsp_fault), 64'(e.fault));
                chk(e.tag, "stage1", 64'(rsp_stage1), 64'(e.s1));
                chk(e.tag, "gpf", 64'(rsp_gpf), 64'(e.gpf));
                chk(e.tag, "walker ops", 64'(ops_total - e.ops_base), 64'(e.ops));
            end
            done_cnt++;
        end
    end

    task automatic ctx(input logic [1:0] priv, input logic virt, input logic [1:0] acc,
                       input logic mprv, input logic mpv, input logic [1:0] mpp,
                       input logic sprv, input logic spv, input logic spp);
        req_priv = priv; req_virt = virt; req_acc = acc;
        st_mprv = mprv; st_mpv = mpv; st_mpp = mpp;
        st_sprv = sprv; st_spv = spv; st_spp = spp;
    endtask

    task automatic issue(input string tag, input logic [VA_W-1:0] va,
                         input logic [PA_W-1:0] pa, input logic f, input logic s1,
                         input logic [PA_W-1:0] gpf, input int ops);
        exp_t e;
        int   tgt;
        @(negedge clk);
        e.tag = tag; e.pa = pa; e.fault = f; e.s1 = s1; e.gpf = gpf;
        e.ops = ops; e.ops_base = ops_total;
        sb_q.push_back(e);
        tgt = done_cnt + 1;
        req_vaddr = va;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
        while (done_cnt < tgt) @(negedge clk);
    endtask

    localparam logic [31:0] VA1 = 32'h0040_1ABC;
    localparam logic [31:0] VA2 = 32'h0080_2123;
    localparam logic [31:0] VA3 = 32'h00C0_3000;

    initial begin
        mem[34'h0010_0004] = 32'h0008_0001;
        mem[34'h0020_0004] = 32'h000D_140F;
        mem[34'h0130_0004] = 32'h0010_0001;
        mem[34'h0140_0004] = 32'h0015_9C0F;
        mem[34'h0130_0008] = 32'h0010_0001;
        mem[34'h0140_0008] = 32'hC015_9C0F;
        mem[34'h0030_0004] = 32'h0020_000F;
        mem[34'h0010_0008] = 32'h0000_0005;
        mem[34'h0010_000C] = 32'h0008_0001;
        mem[34'h0020_000C] = 32'h0008_0001;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R12", "reset req_ready", 64'(req_ready), 64'd1);
        chk("R12", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R12", "reset wk_req_valid", 64'(wk_req_valid), 64'd0);

        // R1: machine mode and bare root pass the address through
        ctx(2'd3, 0, 2'd0, 0, 0, 2'd0, 0, 0, 0);
        issue("R1", VA1, 34'h0040_1ABC, 0, 0, 0, 0);
        root_s_on = 1'b0;
        ctx(2'd1, 0, 2'd0, 0, 0, 2'd0, 0, 0, 0);
        issue("R1", VA1, 34'h0040_1ABC, 0, 0, 0, 0);
        root_s_on = 1'b1;
        // R13: single-stage two-level walk
        issue("R13", VA1, 34'h0034_5ABC, 0, 0, 0, 2);
        // R6/R7: virtualized nested walk
        ctx(2'd1, 1, 2'd0, 0, 0, 2'd0, 0, 0, 0);
        issue("R6", VA1, 34'h0156_7ABC, 0, 0, 0, 5);
        // R8: final second-stage fault
        issue("R8", VA2, 34'h0, 1, 0, 34'h0_C015_9C48, 5);
        // R10: fault value cleared on next request
        issue("R10", VA1, 34'h0156_7ABC, 0, 0, 0, 5);
        // R9: missing entry in two-stage walk
        issue("R9", VA3, 34'h0, 1, 1, 0, 2);
        // R8: table base translation fault
        root_vs_ppn = 22'h30_0000;
        issue("R8", VA1, 34'h0, 1, 0, 34'h0_C000_0000, 1);
        root_vs_ppn = 22'h300;
        // R2: first stage off, only final second stage
        root_vs_on = 1'b0;
        issue("R2", VA1, 34'h0140_1ABC, 0, 0, 0, 1);
        root_vs_on = 1'b1;
        // R7: guest root off passes second stage through
        root_g_on = 1'b0;
        issue("R7", VA1, 34'h0080_1ABC, 0, 0, 0, 3);
        root_g_on = 1'b1;
        // R3: machine modify-privilege overrides
        ctx(2'd3, 0, 2'd0, 1, 1, 2'd1, 0, 0, 0);
        issue("R3", VA1, 34'h0156_7ABC, 0, 0, 0, 5);
        ctx(2'd3, 0, 2'd0, 1, 0, 2'd3, 0, 0, 0);
        issue("R3", VA1, 34'h0040_1ABC, 0, 0, 0, 0);
        ctx(2'd3, 0, 2'd1, 1, 0, 2'd1, 0, 0, 0);
        issue("R3", VA1, 34'h0034_5ABC, 0, 0, 0, 2);
        // R5: fetch ignores the machine override
        ctx(2'd3, 0, 2'd2, 1, 1, 2'd1, 0, 0, 0);
        issue("R5", VA1, 34'h0040_1ABC, 0, 0, 0, 0);
        // R4: supervisor override with and without two stages
        ctx(2'd1, 0, 2'd0, 0, 0, 2'd0, 1, 1, 1);
        issue("R4", VA1, 34'h0156_7ABC, 0, 0, 0, 5);
        ctx(2'd1, 0, 2'd0, 0, 0, 2'd0, 1, 0, 1);
        issue("R11", VA1, 34'h0080_1ABC, 0, 0, 0, 1);
        // R5: fetch ignores the supervisor override
        ctx(2'd1, 0, 2'd2, 0, 0, 2'd0, 1, 1, 1);
        issue("R5", VA1, 34'h0034_5ABC, 0, 0, 0, 2);
        // R9: write without read, and non-leaf at the last level
        ctx(2'd1, 0, 2'd0, 0, 0, 2'd0, 0, 0, 0);
        issue("R9", VA2, 34'h0, 1, 1, 0, 1);
        issue("R9", VA3, 34'h0, 1, 1, 0, 2);

        chk("R12", "scoreboard drained", 64'(sb_q.size()), 64'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL R12 watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule